// File: doc/BRIEF.md
# ADC Interrupt and Vector Controller

This block is the interrupt front end of an analog-to-digital converter. It receives two single-cycle event pulses: one that marks the end of a group of conversions and one from the analog watchdog that marks an input outside its allowed window. Each event latches a sticky flag. A flag raises the single interrupt request only while its enable bit is set. The request travels with a 3-bit priority level taken from the control register.

Both sources share one interrupt vector. Software writes the upper six bits of the vector register as a base. Hardware drives bit 1, a word-select bit, to pick the lower entry (watchdog) or the upper entry (end of conversion). Bit 0 always reads 0. When both sources are active, the watchdog is served first and the end-of-conversion request stays pending. Software can raise either interrupt itself by writing 1 to a flag. Software clears a flag by writing 0 to it.

Software reaches the registers through a simple port. A write takes effect at the clock edge. A read returns the selected register combinationally.

Top module: `adc_irq_ctrl`

## Requirements
- R1: After reset the control register reads 0x0F, the vector register reads 0x02, and `irq_req` is 0. `reg_sel`=0 addresses the control register and `reg_sel`=1 addresses the vector register.
- R2: The control register bits are: 7 end-of-conversion flag, 6 watchdog flag, 5 end-of-conversion enable, 4 watchdog enable, 3 spare (stored and read back), 2:0 priority level. `irq_level` equals bits 2:0.
- R3: An `eoc_evt` pulse sets control bit 7 at the next clock edge. The bit stays set until software writes 0 to it.
- R4: A `wdg_evt` pulse sets control bit 6 at the next clock edge. The bit stays set until software writes 0 to it.
- R5: A software write of 1 to control bit 7 or bit 6 sets that flag. The flag then raises a request exactly as the matching hardware event would.
- R6: `irq_req` is 1 exactly when (bit 7 and bit 5) or (bit 6 and bit 4) is set. A flag with its enable at 0 raises no request.
- R7: Vector bits 7:2 take the written value. Writes to vector bits 1:0 are ignored. Bit 0 always reads 0. `irq_vector` equals the vector register.
- R8: While the watchdog is active (bit 6 and bit 4 set), vector bit 1 is 0, even if end of conversion is also active.
- R9: While end of conversion is active and the watchdog is not, vector bit 1 is 1. This covers the pending end-of-conversion request after the watchdog flag is cleared.
- R10: If a hardware event and a software write of 0 hit the same flag in the same cycle, the flag ends up set.
- R11: While neither source is active, vector bit 1 keeps its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| eoc_evt | input | 1 | End-of-conversion event pulse |
| wdg_evt | input | 1 | Analog watchdog out-of-window pulse |
| reg_sel | input | 1 | Register select: 0 control, 1 vector |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| irq_req | output | 1 | Interrupt request |
| irq_level | output | 3 | Interrupt priority level |
| irq_vector | output | 8 | Vector address including word-select bit |

## Verification
The hardest case to reach from the ports is a hardware event that lands in the same cycle as a software write that clears the same flag. To reach it, the bench raises `eoc_evt` during the exact write cycle and then reads the flag back. The bench also fires both events in one cycle and then clears the watchdog flag alone. This shows the word-select bit move from the lower entry to the held end-of-conversion entry. A further case masks a set flag, so that its event must not move the word-select bit.

// File: rtl/adc_irq_ctrl.sv
module adc_irq_ctrl #(
  parameter logic [2:0] LEVEL_RST = 3'd7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       eoc_evt,
  input  logic       wdg_evt,
  input  logic       reg_sel,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq_req,
  output logic [2:0] irq_level,
  output logic [7:0] irq_vector
);

  logic       eoc_f, wdg_f, eoc_en, wdg_en, spare;
  logic [2:0] level;
  logic [5:0] base;
  logic       wsel;
  logic       eoc_f_n, wdg_f_n, eoc_en_n, wdg_en_n;
  logic       ctl_wr, vec_wr;

  assign ctl_wr = reg_wr && !reg_sel;
  assign vec_wr = reg_wr && reg_sel;

  assign eoc_f_n  = eoc_evt | (ctl_wr ? reg_wdata[7] : eoc_f);
  assign wdg_f_n  = wdg_evt | (ctl_wr ? reg_wdata[6] : wdg_f);
  assign eoc_en_n = ctl_wr ? reg_wdata[5] : eoc_en;
  assign wdg_en_n = ctl_wr ? reg_wdata[4] : wdg_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eoc_f  <= 1'b0;
      wdg_f  <= 1'b0;
      eoc_en <= 1'b0;
      wdg_en <= 1'b0;
      spare  <= 1'b1;
      level  <= LEVEL_RST;
      base   <= '0;
      wsel   <= 1'b1;
    end else begin
      eoc_f  <= eoc_f_n;
      wdg_f  <= wdg_f_n;
      eoc_en <= eoc_en_n;
      wdg_en <= wdg_en_n;
      if (ctl_wr) begin
        spare <= reg_wdata[3];
        level <= reg_wdata[2:0];
      end
      if (vec_wr) base <= reg_wdata[7:2];
      if (wdg_f_n && wdg_en_n)      wsel <= 1'b0;
      else if (eoc_f_n && eoc_en_n) wsel <= 1'b1;
    end
  end

  logic [7:0] ctl_val;
  assign ctl_val    = {eoc_f, wdg_f, eoc_en, wdg_en, spare, level};
  assign irq_vector = {base, wsel, 1'b0};
  assign reg_rdata  = reg_sel ? irq_vector : ctl_val;
  assign irq_req    = (eoc_f && eoc_en) || (wdg_f && wdg_en);
  assign irq_level  = level;

  a_r3_eoc_sets: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_evt |=> ctl_val[7]);
  a_r4_wdg_sets: assert property (@(posedge clk) disable iff (!rst_n)
    wdg_evt |=> ctl_val[6]);
  a_r5_sw_raise: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && reg_wdata[7] && reg_wdata[5]) |=> irq_req);
  a_r6_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_val[5] && !ctl_val[4]) |-> !irq_req);
  a_r7_bit0_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_vector[0]);
  a_r8_wdg_first: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_val[6] && ctl_val[4]) |-> !irq_vector[1]);
  a_r9_eoc_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_val[7] && ctl_val[5] && !(ctl_val[6] && ctl_val[4])) |-> irq_vector[1]);
  a_r10_sw_only_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_val[7] && !ctl_wr) |=> ctl_val[7]);

endmodule

// File: tb/adc_irq_ctrl_tb.sv
module adc_irq_ctrl_tb;
  logic clk = 0, rst_n = 0;
  logic eoc_evt = 0, wdg_evt = 0, reg_sel = 0, reg_wr = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata, irq_vector;
  logic irq_req;
  logic [2:0] irq_level;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  adc_irq_ctrl u_dut (.clk, .rst_n, .eoc_evt, .wdg_evt, .reg_sel, .reg_wr,
    .reg_wdata, .reg_rdata, .irq_req, .irq_level, .irq_vector);

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic sel, logic [7:0] d);
    @(negedge clk); reg_sel = sel; reg_wr = 1; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic pulse(logic e, logic w);
    @(negedge clk); eoc_evt = e; wdg_evt = w;
    @(negedge clk); eoc_evt = 0; wdg_evt = 0;
  endtask

  task automatic rd(logic sel, output logic [7:0] d);
    reg_sel = sel; #1; d = reg_rdata;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    rd(0, d); chk("R1 ctrl", d, 8'h0F);
    rd(1, d); chk("R1 vector", d, 8'h02);
    chk("R1 req", {7'd0, irq_req}, 8'd0);
  endtask

  task automatic t_layout;
    logic [7:0] d;
    wr(0, 8'h0D); rd(0, d); chk("R2 readback", d, 8'h0D);
    chk("R2 level", {5'd0, irq_level}, 8'd5);
    wr(1, 8'hA7); rd(1, d); chk("R7 vector write", d, 8'hA6);
    chk("R7 irq_vector", irq_vector, 8'hA6);
  endtask

  task automatic t_eoc;
    logic [7:0] d;
    wr(0, 8'h27); pulse(1, 0); rd(0, d);
    chk("R3 flag set", d, 8'hA7);
    chk("R6 req", {7'd0, irq_req}, 8'd1);
    chk("R9 upper", irq_vector, 8'hA6);
    repeat (3) @(negedge clk); rd(0, d); chk("R3 sticky", d, 8'hA7);
  endtask

  task automatic t_mask;
    logic [7:0] d;
    wr(0, 8'h03); pulse(0, 1); rd(0, d);
    chk("R4 flag set", d, 8'h43);
    chk("R6 masked", {7'd0, irq_req}, 8'd0);
    chk("R11 hold", irq_vector, 8'hA6);
    wr(0, 8'h53);
    chk("R6 enabled", {7'd0, irq_req}, 8'd1);
    chk("R8 lower", irq_vector, 8'hA4);
  endtask

  task automatic t_both;
    logic [7:0] d;
    wr(0, 8'h33); pulse(1, 1); rd(0, d);
    chk("R3 R4 both", d, 8'hF3);
    chk("R8 wdg first", irq_vector, 8'hA4);
    wr(0, 8'hB3);
    chk("R9 pending", irq_vector, 8'hA6);
    chk("R9 req", {7'd0, irq_req}, 8'd1);
    wr(0, 8'h33);
    chk("R6 cleared", {7'd0, irq_req}, 8'd0);
    chk("R11 hold", irq_vector, 8'hA6);
  endtask

  task automatic t_sw;
    logic [7:0] d;
    wr(0, 8'hB3); rd(0, d);
    chk("R5 sw eoc", d, 8'hB3);
    chk("R5 req", {7'd0, irq_req}, 8'd1);
    wr(0, 8'h73);
    chk("R5 sw wdg", irq_vector, 8'hA4);
  endtask

  task automatic t_race;
    logic [7:0] d;
    wr(0, 8'h23);
    @(negedge clk); reg_sel = 0; reg_wr = 1; reg_wdata = 8'h23; eoc_evt = 1;
    @(negedge clk); reg_wr = 0; eoc_evt = 0;
    rd(0, d); chk("R10 hw wins", d, 8'hA3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset; t_layout; t_eoc; t_mask; t_both; t_sw; t_race;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule